// File: doc/BRIEF.md
# Two-Write-Port Memory Built from Single-Write Banks

This block is a memory with two fully independent ports, A and B. On every clock edge each port can either read one word or write one word, so two writes can land in the same cycle. No storage array inside takes more than one write per cycle. Each port owns a data bank of its own and writes only that bank. Two one-bit flag banks record, for every address, which data bank holds the most recent word.

When the two flag bits at an address are equal, bank A holds the live word. When they differ, bank B holds it. A write on port A makes the flags equal by copying B's flag into A's flag. A write on port B makes them differ by storing the inverse of A's flag into B's flag. A read fetches both data words and both flags at its address. It picks the live word and registers it.

Same-address collisions follow fixed rules. If both ports write the same address in one cycle, port B wins. A read on one port that meets a write on the other port to the same address returns the value held before the write.

Top module: `dpram_flagsel`

## Requirements
- R1: Synchronous active-high reset clears both read outputs and every memory location, so any address read after reset returns zero.
- R2: Read data appears on the port's output exactly one cycle after the read request. The output keeps its value in every cycle that follows a cycle in which the port did not read.
- R3: A word written through port A is returned by a later read of that address on either port.
- R4: A word written through port B is returned by a later read of that address on either port.
- R5: Two writes in the same cycle to different addresses are both stored.
- R6: When both ports write the same address in the same cycle, later reads return port B's word.
- R7: A read on one port and a write to the same address on the other port in the same cycle return the value held before the write (read-before-write).
- R8: Both ports can read in the same cycle, each returning the live word at its own address.
- R9: Across any interleaving of writes from the two ports to one address, a read returns the word from the most recent write.
- R10: A port request is taken only when its enable (`x_en`) is 1. In this encoding `x_we`=1 means write and `x_we`=0 means read. With the enable at 0 the port neither writes nor reads, whatever `x_we` is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| a_en | input | 1 | Port A request enable |
| a_we | input | 1 | Port A write (1) or read (0) |
| a_addr | input | AW | Port A address |
| a_wdata | input | DW | Port A write data |
| a_rdata | output | DW | Port A registered read data |
| b_en | input | 1 | Port B request enable |
| b_we | input | 1 | Port B write (1) or read (0) |
| b_addr | input | AW | Port B address |
| b_wdata | input | DW | Port B write data |
| b_rdata | output | DW | Port B registered read data |

## Verification
The bench builds the block with AW=4 and DW=16. With only sixteen addresses, random traffic on both ports often sends both ports to the same address in the same cycle. This exercises every flag pair, both collision rules and long chains of alternating writes from the two ports. Sixteen-bit data keeps a stale word from matching the expected one by chance. The small depth also lets a directed pass read every address after reset.

// File: rtl/dpf_pkg.sv
package dpf_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } dpf_op_e;

  function automatic dpf_op_e dpf_decode(input logic en, input logic we);
    if (!en)     return OP_IDLE;
    else if (we) return OP_WRITE;
    else         return OP_READ;
  endfunction

endpackage

// File: rtl/dpf_bank.sv
// One storage bank: a single write port and two asynchronous read taps.
module dpf_bank #(
  parameter int AW = 6,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr0,
  input  logic [AW-1:0] raddr1,
  output logic [DW-1:0] rdata0,
  output logic [DW-1:0] rdata1
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata0 = mem[raddr0];
  assign rdata1 = mem[raddr1];

endmodule

// File: rtl/dpf_flag_ctrl.sv
// Computes the new flag bits for the write ports, including the collision override.
module dpf_flag_ctrl #(
  parameter int AW = 6
) (
  input  logic          a_wr,
  input  logic          b_wr,
  input  logic [AW-1:0] a_addr,
  input  logic [AW-1:0] b_addr,
  input  logic          fa_at_a,
  input  logic          fb_at_a,
  input  logic          fa_at_b,
  input  logic          fb_at_b,
  output logic          fa_we,
  output logic          fa_wval,
  output logic          fb_we,
  output logic          fb_wval
);
  logic collide;

  always_comb begin
    collide = a_wr && b_wr && (a_addr == b_addr);
    // A write: make the flags equal so bank A becomes live.
    fa_we   = a_wr;
    fa_wval = fb_at_a;
    // B write: make the flags differ. On a collision, derive from B's own old
    // flag, because A's flag is being rewritten to that same value.
    fb_we   = b_wr;
    fb_wval = collide ? ~fb_at_b : ~fa_at_b;
  end

  logic unused_fa_at_a;
  assign unused_fa_at_a = fa_at_a;

endmodule

// File: rtl/dpf_read_sel.sv
// Picks the live word for one port and registers it.
module dpf_read_sel #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd,
  input  logic [DW-1:0] dat_a,
  input  logic [DW-1:0] dat_b,
  input  logic          flag_a,
  input  logic          flag_b,
  output logic [DW-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= (flag_a == flag_b) ? dat_a : dat_b;
  end
endmodule

// File: rtl/dpram_flagsel.sv
module dpram_flagsel
  import dpf_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          a_en,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic          b_en,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata
);
  localparam int NPORT = 2;

  dpf_op_e a_op, b_op;
  logic    a_wr, b_wr;
  logic [NPORT-1:0] port_rd;

  assign a_op = dpf_decode(a_en, a_we);
  assign b_op = dpf_decode(b_en, b_we);
  assign a_wr = (a_op == OP_WRITE);
  assign b_wr = (b_op == OP_WRITE);
  assign port_rd[0] = (a_op == OP_READ);
  assign port_rd[1] = (b_op == OP_READ);

  // Bank contents seen at each port's address.
  logic [DW-1:0] da_at [NPORT];
  logic [DW-1:0] db_at [NPORT];
  logic [0:0]    fa_at [NPORT];
  logic [0:0]    fb_at [NPORT];

  logic fa_we, fa_wval, fb_we, fb_wval;

  dpf_bank #(.AW(AW), .DW(DW)) u_data_a (
    .clk(clk), .rst(rst), .we(a_wr), .waddr(a_addr), .wdata(a_wdata),
    .raddr0(a_addr), .raddr1(b_addr), .rdata0(da_at[0]), .rdata1(da_at[1])
  );

  dpf_bank #(.AW(AW), .DW(DW)) u_data_b (
    .clk(clk), .rst(rst), .we(b_wr), .waddr(b_addr), .wdata(b_wdata),
    .raddr0(a_addr), .raddr1(b_addr), .rdata0(db_at[0]), .rdata1(db_at[1])
  );

  dpf_bank #(.AW(AW), .DW(1)) u_flag_a (
    .clk(clk), .rst(rst), .we(fa_we), .waddr(a_addr), .wdata(fa_wval),
    .raddr0(a_addr), .raddr1(b_addr), .rdata0(fa_at[0]), .rdata1(fa_at[1])
  );

  dpf_bank #(.AW(AW), .DW(1)) u_flag_b (
    .clk(clk), .rst(rst), .we(fb_we), .waddr(b_addr), .wdata(fb_wval),
    .raddr0(a_addr), .raddr1(b_addr), .rdata0(fb_at[0]), .rdata1(fb_at[1])
  );

  dpf_flag_ctrl #(.AW(AW)) u_flag_ctrl (
    .a_wr(a_wr), .b_wr(b_wr), .a_addr(a_addr), .b_addr(b_addr),
    .fa_at_a(fa_at[0][0]), .fb_at_a(fb_at[0][0]),
    .fa_at_b(fa_at[1][0]), .fb_at_b(fb_at[1][0]),
    .fa_we(fa_we), .fa_wval(fa_wval), .fb_we(fb_we), .fb_wval(fb_wval)
  );

  logic [DW-1:0] rdata_p [NPORT];

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    dpf_read_sel #(.DW(DW)) u_sel (
      .clk(clk), .rst(rst), .rd(port_rd[p]),
      .dat_a(da_at[p]), .dat_b(db_at[p]),
      .flag_a(fa_at[p][0]), .flag_b(fb_at[p][0]),
      .rdata(rdata_p[p])
    );
  end

  assign a_rdata = rdata_p[0];
  assign b_rdata = rdata_p[1];

endmodule

// File: rtl/dpf_checker.sv
module dpf_checker #(
  parameter int AW = 6,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          a_en,
  input logic          a_we,
  input logic [AW-1:0] a_addr,
  input logic [DW-1:0] a_wdata,
  input logic [DW-1:0] a_rdata,
  input logic          b_en,
  input logic          b_we,
  input logic [AW-1:0] b_addr,
  input logic [DW-1:0] b_wdata,
  input logic [DW-1:0] b_rdata,
  input logic          fa_we,
  input logic          fa_wval,
  input logic          fb_we,
  input logic          fb_wval
);
  // R1: reset clears both outputs on the next edge.
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (a_rdata == '0 && b_rdata == '0));

  // R2: with no read on a port, its output holds.
  assert_hold_a_R2: assert property (@(posedge clk) disable iff (rst)
    !(a_en && !a_we) |=> $stable(a_rdata));
  assert_hold_b_R2: assert property (@(posedge clk) disable iff (rst)
    !(b_en && !b_we) |=> $stable(b_rdata));

  // R6: a same-address double write leaves the flags different (bank B live).
  assert_collide_b_live_R6: assert property (@(posedge clk) disable iff (rst)
    (fa_we && fb_we && a_en && a_we && b_en && b_we && a_addr == b_addr)
      |-> (fa_wval != fb_wval));

  // R3: port A write, then port A read of the same address, returns it.
  assert_a_write_read_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && a_en && !a_we && $past(a_en && a_we) &&
     $past(a_addr) == a_addr && !$past(b_en && b_we && b_addr == a_addr))
      |=> (a_rdata == $past(a_wdata, 2)));

  // R4: port B write, then port B read of the same address, returns it.
  assert_b_write_read_R4: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && b_en && !b_we && $past(b_en && b_we) &&
     $past(b_addr) == b_addr)
      |=> (b_rdata == $past(b_wdata, 2)));
endmodule

bind dpram_flagsel dpf_checker #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst),
  .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
  .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata),
  .fa_we(fa_we), .fa_wval(fa_wval), .fb_we(fb_we), .fb_wval(fb_wval)
);

// File: tb/dpram_flagsel_tb.sv
`timescale 1ns/1ps
module dpram_flagsel_tb;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic          rst;
  logic          a_en, a_we, b_en, b_we;
  logic [AW-1:0] a_addr, b_addr;
  logic [DW-1:0] a_wdata, b_wdata, a_rdata, b_rdata;

  dpram_flagsel #(.AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst(rst),
    .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
    .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata)
  );

  typedef struct {
    int            due;
    logic [DW-1:0] exp;
    string         tag;
  } item_t;

  item_t         qa[$];
  item_t         qb[$];
  logic [DW-1:0] model [DEPTH];
  logic [DW-1:0] last_a, last_b;
  int            cyc = 0;
  int            n_run = 0;
  int            n_fail = 0;
  bit            done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Monitor: pop scoreboard items as their cycle comes due.
  always @(negedge clk) begin
    item_t it;
    if (qa.size() > 0 && qa[0].due == cyc) begin
      it = qa.pop_front();
      check(it.tag, "port A", a_rdata, it.exp);
    end
    if (qb.size() > 0 && qb[0].due == cyc) begin
      it = qb.pop_front();
      check(it.tag, "port B", b_rdata, it.exp);
    end
  end

  // Driver: one cycle of stimulus on both ports, plus expected results.
  task automatic step(input logic ae, input logic awe, input int aad, input int awd,
                      input logic be, input logic bwe, input int bad, input int bwd,
                      input string tag);
    item_t it;
    @(negedge clk);
    a_en = ae; a_we = awe; a_addr = AW'(aad); a_wdata = DW'(awd);
    b_en = be; b_we = bwe; b_addr = AW'(bad); b_wdata = DW'(bwd);
    if (ae && !awe) last_a = model[AW'(aad)];
    if (be && !bwe) last_b = model[AW'(bad)];
    it.due = cyc + 1; it.exp = last_a; it.tag = (ae && !awe) ? tag : "R2";
    qa.push_back(it);
    it.exp = last_b; it.tag = (be && !bwe) ? tag : "R2";
    qb.push_back(it);
    // Reads see old contents; B is applied after A so B wins a collision.
    if (ae && awe) model[AW'(aad)] = DW'(awd);
    if (be && bwe) model[AW'(bad)] = DW'(bwd);
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, "R2");
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    last_a = '0; last_b = '0;
    rst = 1'b1;
    a_en = 0; a_we = 0; a_addr = '0; a_wdata = '0;
    b_en = 0; b_we = 0; b_addr = '0; b_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "port A after reset", a_rdata, '0);
    check("R1", "port B after reset", b_rdata, '0);
    rst = 1'b0;

    // R1: every address reads zero after reset
    for (int i = 0; i < DEPTH; i++) step(1, 0, i, 0, 1, 0, DEPTH - 1 - i, 0, "R1");

    // R3: port A write, readback on both ports
    step(1, 1, 3, 16'h1234, 0, 0, 0, 0, "R3");
    step(1, 0, 3, 0, 1, 0, 3, 0, "R3");
    // R4: port B write, readback on both ports
    step(0, 0, 0, 0, 1, 1, 5, 16'h5a5a, "R4");
    step(1, 0, 5, 0, 1, 0, 5, 0, "R4");
    // R2: idle cycles hold the outputs
    idle(); idle();
    // R5: simultaneous writes to different addresses
    step(1, 1, 6, 16'h0606, 1, 1, 7, 16'h0707, "R5");
    step(1, 0, 7, 0, 1, 0, 6, 0, "R5");
    step(1, 0, 6, 0, 1, 0, 7, 0, "R5");
    // R6: same-address collisions from several flag states
    step(1, 1, 9, 16'h1111, 1, 1, 9, 16'h2222, "R6");
    step(1, 0, 9, 0, 1, 0, 9, 0, "R6");
    step(1, 1, 9, 16'h3333, 0, 0, 0, 0, "R6");
    step(1, 1, 9, 16'h4444, 1, 1, 9, 16'h5555, "R6");
    step(1, 0, 9, 0, 1, 0, 9, 0, "R6");
    step(0, 0, 0, 0, 1, 1, 9, 16'h6666, "R6");
    step(1, 1, 9, 16'h7777, 1, 1, 9, 16'h8888, "R6");
    step(1, 0, 9, 0, 1, 0, 9, 0, "R6");
    // R7: read meets write on the other port, same address
    step(1, 1, 10, 16'haaaa, 0, 0, 0, 0, "R7");
    step(1, 0, 10, 0, 1, 1, 10, 16'hbbbb, "R7");
    step(1, 0, 10, 0, 1, 0, 10, 0, "R7");
    step(1, 1, 10, 16'hcccc, 1, 0, 10, 0, "R7");
    step(1, 0, 10, 0, 1, 0, 10, 0, "R7");
    // R8: both ports read different addresses together
    step(1, 0, 5, 0, 1, 0, 3, 0, "R8");
    step(1, 0, 6, 0, 1, 0, 9, 0, "R8");
    // R9: alternating writes to one address
    step(1, 1, 11, 16'h0b01, 0, 0, 0, 0, "R9");
    step(0, 0, 0, 0, 1, 1, 11, 16'h0b02, "R9");
    step(1, 1, 11, 16'h0b03, 0, 0, 0, 0, "R9");
    step(1, 0, 11, 0, 1, 0, 11, 0, "R9");
    step(0, 0, 0, 0, 1, 1, 11, 16'h0b04, "R9");
    step(0, 0, 0, 0, 1, 1, 11, 16'h0b05, "R9");
    step(1, 0, 11, 0, 1, 0, 11, 0, "R9");
    // R10: disabled ports neither write nor read
    step(0, 1, 3, 16'hdead, 0, 1, 5, 16'hbeef, "R10");
    step(0, 0, 3, 0, 0, 0, 5, 0, "R10");
    step(1, 0, 3, 0, 1, 0, 5, 0, "R10");

    // R9: random traffic with frequent same-address meetings
    for (int n = 0; n < 4000; n++) begin
      int aad, bad;
      aad = $urandom_range(DEPTH - 1);
      bad = ($urandom_range(2) == 0) ? aad : $urandom_range(DEPTH - 1);
      step($urandom_range(3) != 0, $urandom_range(1) == 1, aad, $urandom,
           $urandom_range(3) != 0, $urandom_range(1) == 1, bad, $urandom, "R9");
    end
    idle(); idle(); idle();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule